// File: doc/BRIEF.md
# Integer Line-Multiplying Video Scaler

This block enlarges a 240-line progressive picture by a whole factor of two, three or four without storing a frame. Each incoming line goes into one half of a two-bank on-chip line store while the other half, which holds the most recent complete line, is replayed onto several output lines. Within each output line, every stored pixel is sent out on as many consecutive pixel clocks as the factor. The only delay is one line plus one clock, far below a frame time.

The source side is a pixel stream: `in_valid` marks a beat, and `in_sol` (or `in_sof`) marks the first pixel of a line. `in_ready` is held high. The block never applies back-pressure, so the source may present a beat on any cycle and every beat it presents is consumed in that cycle. The output side follows an external timing generator that supplies hsync, vsync and data-enable. The block returns those three strobes one clock later, aligned with the pixel data it reads. The output line rate is assumed to be an exact multiple of the input line rate. Three plain controls set the factor, darken the last repeated copy of each line to mimic scanline gaps, and freeze the picture.

Top module: `line_multiplier`

## Requirements
- R1: After reset, `out_hsync`, `out_vsync` and `out_de` are 0, `out_data` is 0, and `in_ready` is 1.
- R2: `out_hsync`, `out_vsync` and `out_de` equal `t_hsync`, `t_vsync` and `t_de` delayed by exactly one clock.
- R3: On the k-th clock (k from 0) of an output active period with factor N, `out_data` is stored pixel floor(k/N) of the selected line. The horizontal position restarts at pixel 0 whenever `t_de` is low. `out_data` is 0 while `out_de` is 0.
- R4: Counting from the rising edge of `t_vsync`, output active lines form groups of N. Copy index 0 through N-1 within a group all show the same stored line, chosen when copy 0 starts.
- R5: The stored line chosen at a group start is the most recently completed input line. While a new line is being written, it is the line before that one. A new line goes into the bank that is not being read.
- R6: `scale_sel` is decoded as 0 = 2x, 1 = 3x, 2 or 3 = 4x. It is sampled only on a rising edge of `t_vsync`, so a change between vsyncs has no effect on the current frame. The factor after reset is 2x.
- R7: Pixels are `{red, green, blue}`, each channel CW bits wide, with red in the top bits. When `scan_en` is 1, copy N-1 of each group is output with every channel shifted right by one bit. When `scan_en` is 0, all copies are identical.
- R8: While `freeze` is 1, accepted beats change neither the stored lines nor the write position. Output groups keep replaying the line that was shown last.
- R9: Beats with `in_sof` set start a line, the same as beats with `in_sol`. Beats past pixel DEPTH-1 of a line are discarded and leave the stored pixels unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for both sides |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Source pixel beat present |
| in_ready | output | 1 | Always 1; every beat is consumed |
| in_data | input | 3*CW | Source pixel {R,G,B} |
| in_sol | input | 1 | Beat is the first pixel of a line |
| in_sof | input | 1 | Beat is the first pixel of a frame (also starts a line) |
| scale_sel | input | 2 | Factor select: 0=2x, 1=3x, 2/3=4x |
| scan_en | input | 1 | Darken the last copy of each line |
| freeze | input | 1 | Hold the stored picture |
| t_hsync | input | 1 | Output horizontal sync from the timing generator |
| t_vsync | input | 1 | Output vertical sync from the timing generator |
| t_de | input | 1 | Output data-enable from the timing generator |
| out_hsync | output | 1 | Delayed horizontal sync |
| out_vsync | output | 1 | Delayed vertical sync |
| out_de | output | 1 | Delayed data-enable |
| out_data | output | 3*CW | Output pixel {R,G,B} |

## Verification
The assertions assume that `t_de` is low while `t_vsync` rises. They also assume that a source line is never longer than DEPTH beats plus a few extra beats that should be discarded, and that input markers come only on valid beats. The stimulus keeps to these rules. It writes one whole line and only then plays that line's full group of N output lines. Vsync pulses are placed only in blanking, and `freeze` and `scale_sel` are changed only between lines. Under this schedule the line being replayed is always the one just completed.

// File: rtl/line_mult_pkg.sv
package line_mult_pkg;

  localparam int FACTOR_W = 3;

  function automatic logic [FACTOR_W-1:0] factor_of(input logic [1:0] sel);
    case (sel)
      2'd0:    factor_of = 3'd2;
      2'd1:    factor_of = 3'd3;
      default: factor_of = 3'd4;
    endcase
  endfunction

endpackage

// File: rtl/lm_linebuf.sv
module lm_linebuf #(
  parameter int DW    = 24,
  parameter int DEPTH = 320,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic          wbank,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          rbank,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int IW = $clog2(2 * DEPTH);

  logic [DW-1:0] mem [2*DEPTH];
  logic [IW-1:0] widx, ridx;

  assign widx = wbank ? IW'(DEPTH) + IW'(waddr) : IW'(waddr);
  assign ridx = rbank ? IW'(DEPTH) + IW'(raddr) : IW'(raddr);

  always_ff @(posedge clk) begin
    if (we) mem[widx] <= wdata;
    rdata <= mem[ridx];
  end
endmodule

// File: rtl/lm_wr_ctrl.sv
module lm_wr_ctrl #(
  parameter int DEPTH = 320,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic          in_sol,
  input  logic          in_sof,
  input  logic          freeze,
  output logic          we,
  output logic          wbank,
  output logic [AW-1:0] waddr,
  output logic          src_bank
);
  localparam logic [AW:0] LIMIT = (AW+1)'(DEPTH);

  logic          bank_q;
  logic [AW:0]   cnt_q;
  logic          start;
  logic [AW:0]   addr_eff;
  logic          in_range;

  assign start    = in_valid & (in_sol | in_sof);
  assign addr_eff = start ? '0 : cnt_q;
  assign in_range = addr_eff < LIMIT;
  assign wbank    = (start & ~freeze) ? ~bank_q : bank_q;
  assign waddr    = addr_eff[AW-1:0];
  assign we       = in_valid & ~freeze & in_range;
  // a finished line lives in the current bank; a partial one means the other bank is newest
  assign src_bank = (cnt_q == LIMIT) ? bank_q : ~bank_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bank_q <= 1'b0;
      cnt_q  <= '0;
    end else if (in_valid && !freeze) begin
      bank_q <= wbank;
      cnt_q  <= in_range ? addr_eff + 1'b1 : addr_eff;
    end
  end

  assert_frozen_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (freeze && in_valid) |=> ($stable(bank_q) && $stable(cnt_q)));

  assert_cnt_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LIMIT);

  assert_line_restart_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !freeze) |=> (cnt_q == 1));
endmodule

// File: rtl/lm_rd_ctrl.sv
module lm_rd_ctrl
  import line_mult_pkg::*;
#(
  parameter int DEPTH = 320,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          t_vsync,
  input  logic          t_de,
  input  logic [1:0]    scale_sel,
  input  logic          src_bank,
  output logic          rbank,
  output logic [AW-1:0] raddr,
  output logic          last_copy
);
  localparam logic [AW-1:0] LAST_ADDR = AW'(DEPTH - 1);

  logic                vs_q, de_q;
  logic [FACTOR_W-1:0] n_q;
  logic [1:0]          sub_q, copy_q;
  logic [AW-1:0]       addr_q;
  logic                rbank_q;
  logic                vs_rise, de_rise, de_fall, group_start;
  logic [FACTOR_W-1:0] n_last;

  assign vs_rise     = t_vsync & ~vs_q;
  assign de_rise     = t_de & ~de_q;
  assign de_fall     = ~t_de & de_q;
  assign n_last      = n_q - 3'd1;
  assign group_start = de_rise && (copy_q == 2'd0);
  assign rbank       = group_start ? src_bank : rbank_q;
  assign raddr       = addr_q;
  assign last_copy   = ({1'b0, copy_q} == n_last);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vs_q    <= 1'b0;
      de_q    <= 1'b0;
      n_q     <= 3'd2;
      copy_q  <= '0;
      rbank_q <= 1'b0;
    end else begin
      vs_q <= t_vsync;
      de_q <= t_de;
      if (group_start) rbank_q <= src_bank;
      if (vs_rise) begin
        n_q    <= factor_of(scale_sel);
        copy_q <= '0;
      end else if (de_fall) begin
        copy_q <= last_copy ? 2'd0 : copy_q + 2'd1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sub_q  <= '0;
      addr_q <= '0;
    end else if (!t_de) begin
      sub_q  <= '0;
      addr_q <= '0;
    end else if ({1'b0, sub_q} == n_last) begin
      sub_q  <= '0;
      if (addr_q != LAST_ADDR) addr_q <= addr_q + 1'b1;
    end else begin
      sub_q <= sub_q + 2'd1;
    end
  end

  assert_scale_latch_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(t_vsync && !vs_q) |=> $stable(n_q));

  assert_factor_legal_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (n_q >= 3'd2) && (n_q <= 3'd4));

  assert_sub_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    {1'b0, sub_q} < n_q);

  assert_addr_restart_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !t_de |=> (addr_q == '0));

  assert_addr_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (t_de && ({1'b0, sub_q} != n_last)) |=> $stable(addr_q));

  assert_copy_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
    {1'b0, copy_q} < n_q);

  assert_bank_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (t_de && de_q) |=> $stable(rbank_q));
endmodule

// File: rtl/line_multiplier.sv
module line_multiplier #(
  parameter int CW    = 8,
  parameter int DEPTH = 320,
  parameter int DW    = 3 * CW,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [DW-1:0] in_data,
  input  logic          in_sol,
  input  logic          in_sof,
  input  logic [1:0]    scale_sel,
  input  logic          scan_en,
  input  logic          freeze,
  input  logic          t_hsync,
  input  logic          t_vsync,
  input  logic          t_de,
  output logic          out_hsync,
  output logic          out_vsync,
  output logic          out_de,
  output logic [DW-1:0] out_data
);
  logic          we, wbank, src_bank, rbank, last_copy;
  logic [AW-1:0] waddr, raddr;
  logic [DW-1:0] rdata, dimmed;
  logic          dim_d;

  assign in_ready = 1'b1;

  lm_wr_ctrl #(.DEPTH(DEPTH), .AW(AW)) u_wr (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sol(in_sol),
    .in_sof(in_sof), .freeze(freeze), .we(we), .wbank(wbank),
    .waddr(waddr), .src_bank(src_bank)
  );

  lm_rd_ctrl #(.DEPTH(DEPTH), .AW(AW)) u_rd (
    .clk(clk), .rst_n(rst_n), .t_vsync(t_vsync), .t_de(t_de),
    .scale_sel(scale_sel), .src_bank(src_bank), .rbank(rbank),
    .raddr(raddr), .last_copy(last_copy)
  );

  lm_linebuf #(.DW(DW), .DEPTH(DEPTH), .AW(AW)) u_buf (
    .clk(clk), .we(we), .wbank(wbank), .waddr(waddr), .wdata(in_data),
    .rbank(rbank), .raddr(raddr), .rdata(rdata)
  );

  for (genvar c = 0; c < 3; c++) begin : g_dim
    assign dimmed[c*CW +: CW] = {1'b0, rdata[c*CW+1 +: CW-1]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_hsync <= 1'b0;
      out_vsync <= 1'b0;
      out_de    <= 1'b0;
      dim_d     <= 1'b0;
    end else begin
      out_hsync <= t_hsync;
      out_vsync <= t_vsync;
      out_de    <= t_de;
      dim_d     <= t_de & scan_en & last_copy;
    end
  end

  assign out_data = !out_de ? '0 : (dim_d ? dimmed : rdata);

  assert_align_R2: assert property (@(posedge clk) disable iff (!rst_n)
    t_de |=> out_de);

  assert_dim_msb_R7: assert property (@(posedge clk) disable iff (!rst_n)
    dim_d |-> (out_data[DW-1] == 1'b0 && out_data[CW-1] == 1'b0));

  assert_ready_R1: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready);
endmodule

// File: tb/line_multiplier_bench.sv
module line_multiplier_bench;
  localparam int CW    = 4;
  localparam int DEPTH = 8;
  localparam int DW    = 3 * CW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0, in_sol = 1'b0, in_sof = 1'b0;
  logic          in_ready;
  logic [DW-1:0] in_data = '0;
  logic [1:0]    scale_sel = 2'd0;
  logic          scan_en = 1'b0, freeze = 1'b0;
  logic          t_hsync = 1'b0, t_vsync = 1'b0, t_de = 1'b0;
  logic          out_hsync, out_vsync, out_de;
  logic [DW-1:0] out_data;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  line_multiplier #(.CW(CW), .DEPTH(DEPTH)) u_line_multiplier (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_sol(in_sol), .in_sof(in_sof),
    .scale_sel(scale_sel), .scan_en(scan_en), .freeze(freeze),
    .t_hsync(t_hsync), .t_vsync(t_vsync), .t_de(t_de),
    .out_hsync(out_hsync), .out_vsync(out_vsync), .out_de(out_de),
    .out_data(out_data)
  );

  function automatic logic [DW-1:0] pix(int line, int x);
    logic [CW-1:0] r, g, b;
    r = CW'((line * 3 + x) % 16);
    g = CW'((x * 5 + line * 2 + 1) % 16);
    b = CW'((line + x * 7 + 9) % 16);
    return {r, g, b};
  endfunction

  function automatic logic [DW-1:0] halve(logic [DW-1:0] p);
    return {1'b0, p[DW-1:2*CW+1], 1'b0, p[2*CW-1:CW+1], 1'b0, p[CW-1:1]};
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic send_line(int line, int beats, bit use_sof);
    for (int b = 0; b < beats; b++) begin
      @(negedge clk);
      in_valid = 1'b1;
      in_sol   = (b == 0) && !use_sof;
      in_sof   = (b == 0) && use_sof;
      in_data  = (b < DEPTH) ? pix(line, b) : ~pix(line, b - DEPTH);
    end
    @(negedge clk);
    in_valid = 1'b0; in_sol = 1'b0; in_sof = 1'b0;
    chk(in_ready == 1'b1, "R9 ready", int'(in_ready), 1);
  endtask

  task automatic vsync_pulse();
    @(negedge clk);
    t_vsync = 1'b1;
    @(negedge clk);
    chk(out_vsync == 1'b1, "R2 vsync delay", int'(out_vsync), 1);
    t_vsync = 1'b0;
    @(negedge clk);
    chk(out_vsync == 1'b0, "R2 vsync fall", int'(out_vsync), 0);
  endtask

  // one output line; k-th active clock must carry stored pixel k/n
  task automatic show_line(int line, int n, bit dim, string req);
    int len;
    logic [DW-1:0] e;
    len = DEPTH * n;
    for (int k = 0; k <= len + 2; k++) begin
      @(negedge clk);
      if (k >= 1 && k <= len) begin
        e = pix(line, (k - 1) / n);
        if (dim) e = halve(e);
        chk(out_de == 1'b1, "R2 de delay", int'(out_de), 1);
        chk(out_data == e, req, int'(out_data), int'(e));
      end
      if (k == len + 1)
        chk(out_de == 1'b0 && out_data == '0, "R3 blank data", int'(out_data), 0);
      if (k == len + 2)
        chk(out_hsync == 1'b1, "R2 hsync delay", int'(out_hsync), 1);
      t_de    = (k < len);
      t_hsync = (k == len + 1);
    end
    @(negedge clk);
    t_hsync = 1'b0;
  endtask

  task automatic show_group(int line, int n, bit scan, string req);
    for (int c = 0; c < n; c++) show_line(line, n, scan && (c == n - 1), req);
  endtask

  initial begin
    #2000000;
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(out_de == 1'b0 && out_hsync == 1'b0 && out_vsync == 1'b0,
        "R1 reset strobes", {out_de, out_hsync, out_vsync}, 0);
    chk(out_data == '0, "R1 reset data", int'(out_data), 0);
    chk(in_ready == 1'b1, "R1 ready", int'(in_ready), 1);
    rst_n = 1'b1;

    // 2x, plain
    vsync_pulse();
    send_line(0, DEPTH, 1'b1);
    show_group(0, 2, 1'b0, "R3 R4 2x line0 via sof R9");
    send_line(1, DEPTH, 1'b0);
    show_group(1, 2, 1'b0, "R5 newest line 2x");

    // scanline on
    scan_en = 1'b1;
    send_line(2, DEPTH, 1'b0);
    show_group(2, 2, 1'b1, "R7 dim last copy 2x");

    // factor change mid-frame must wait for vsync
    scale_sel = 2'd1;
    send_line(3, DEPTH, 1'b0);
    show_group(3, 2, 1'b1, "R6 mid-frame keeps 2x");
    vsync_pulse();
    send_line(4, DEPTH, 1'b0);
    show_group(4, 3, 1'b1, "R6 R7 3x after vsync");

    // 4x with overlong line
    scale_sel = 2'd2;
    scan_en   = 1'b0;
    vsync_pulse();
    send_line(5, DEPTH + 3, 1'b0);
    show_group(5, 4, 1'b0, "R9 R3 4x extra beats dropped");

    // freeze
    freeze = 1'b1;
    send_line(6, DEPTH, 1'b0);
    show_group(5, 4, 1'b0, "R8 frozen replay");
    send_line(7, DEPTH, 1'b1);
    show_group(5, 4, 1'b0, "R8 frozen replay again");
    freeze = 1'b0;
    send_line(8, DEPTH, 1'b0);
    show_group(8, 4, 1'b0, "R8 R5 unfrozen new line");

    // code 3 is 4x, scanline on
    scale_sel = 2'd3;
    scan_en   = 1'b1;
    vsync_pulse();
    send_line(9, DEPTH, 1'b0);
    show_group(9, 4, 1'b1, "R6 R7 code3 4x");

    // back to 2x, scanline off
    scale_sel = 2'd0;
    scan_en   = 1'b0;
    vsync_pulse();
    send_line(10, DEPTH, 1'b0);
    show_group(10, 2, 1'b0, "R4 R6 return to 2x");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule